// File: doc/BRIEF.md
# Reset Sequencer and Boot-Mode Strap Latch

This block sequences reset for a small microcontroller core and decides the operating mode it starts in. The reset pad is bidirectional and open-drain. It is modelled as a sampled input level and a pull-down enable output. A falling edge on that pad, or a one-cycle request from inside the chip, starts a pull-down pulse of fixed length. The core stays in reset for as long as the pulse runs or the pad reads low. When the core leaves reset, the block presents the boot fetch address.

The pad is sampled through a two-flop synchroniser. When the sampled pad rises, the block captures two active-low strap inputs. One strap selects on-circuit emulation, in which every pin except the two oscillator pins is tristated. The other strap selects a reserved test mode. A mode holds until the pad reads low again. An option keeps internal resets off the pad: the core is still reset, but the pad and the latched mode are left alone.

The block also tracks the low-power states of the core. It enters idle on request. It enters powerdown only when the configuration enable bit is set. A reset through the pad leaves either state and returns the core to run. Powerdown can also be left by holding the programming-voltage input low for a qualified number of clocks. That exit restarts the phase clocks but leaves the oscillator enable off.

Top module: `rst_mode_ctl`

## Requirements
- R1: A falling edge on the synchronised reset pad, or an internal reset request, drives `rstPinPullDn` high for exactly PULSE_STATES clocks (default 16). The pad input passes through two synchroniser flops before the edge is detected.
- R2: A falling edge or an internal request that arrives while a pulse is running does not restart or extend it. A pad held low for longer than the pulse still produces exactly one pulse.
- R3: `coreRst` is 1 while a pulse runs or the synchronised pad reads low, and it falls one clock after both have cleared. On the clock that `coreRst` falls, `bootFetch` pulses for one cycle and `bootAddr` reads 16'h2080.
- R4: When the synchronised pad rises, `emuStrapN` is captured. A 0 there sets `modeEmu`. `modeEmu` and `modeTest` clear while the synchronised pad reads low.
- R5: While `modeEmu` is 1, every bit of `pinTristate` is 1 except bits OSC_PIN_A and OSC_PIN_B (defaults 14 and 15), so the default vector is 16'h3FFF. Otherwise the vector is all zero.
- R6: `testStrapN` = 0 with `emuStrapN` = 1 at capture sets `modeTest`. When both straps are 0, only `modeEmu` is set. `modeNormal` is 1 exactly when neither mode is set.
- R7: With `cfgIntRstQuiet` = 1, an internal reset still asserts `coreRst` but never drives `rstPinPullDn`, and the latched mode is left unchanged.
- R8: `pdReq` moves the core to powerdown (`pdMode` = 1, `phaseClkEn` = 0, `oscEn` = 0) only when `pdEnable` = 1. Otherwise the request is ignored.
- R9: In powerdown, `vppN` held low for WAKE_CYCLES consecutive synchronised samples (default 5) returns the core to run with `phaseClkEn` = 1 and `oscEn` still 0. A shorter low has no effect.
- R10: A pad reset while in idle or powerdown returns the core to run, with `idleMode` = 0, `pdMode` = 0 and `oscEn` = 1.
- R11: `idleReq` in run, with no reset active, sets `idleMode`, and the phase clocks stay enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-time clock, free-running |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| rstPinIn | input | 1 | Sampled level of the open-drain reset pad |
| rstPinPullDn | output | 1 | Enable for the reset pad pull-down |
| intRstReq | input | 1 | Internal reset request, one-cycle strobe |
| cfgIntRstQuiet | input | 1 | 1 keeps internal resets off the pad |
| emuStrapN | input | 1 | Emulation strap, active low |
| testStrapN | input | 1 | Reserved test strap, active low |
| idleReq | input | 1 | Request to enter idle |
| pdReq | input | 1 | Request to enter powerdown |
| pdEnable | input | 1 | Configuration bit that permits powerdown |
| vppN | input | 1 | Programming-voltage pin level, low to wake |
| coreRst | output | 1 | Reset to the core |
| bootFetch | output | 1 | One-cycle strobe for the first fetch |
| bootAddr | output | 16 | Address of the first fetch |
| modeNormal | output | 1 | Normal operating mode |
| modeEmu | output | 1 | On-circuit emulation mode |
| modeTest | output | 1 | Reserved test mode |
| pinTristate | output | NUM_PINS | Per-pin tristate enables |
| idleMode | output | 1 | Core is idle |
| pdMode | output | 1 | Core is powered down |
| phaseClkEn | output | 1 | Enable for the internal phase clocks |
| oscEn | output | 1 | Enable for the oscillator |

## Verification
The reset pulse is triggered by a short external low, a long external low, a loud internal request and a quiet internal request. Comparing the measured pulse lengths with the expected ones separates a counter that restarts on its own echo from one that ignores it, and a pad-driving internal reset from a quiet one. Four strap combinations (none low, emulation, test, both) are captured. They separate the priority of emulation over test and show that a quiet reset does not re-capture the straps. The powerdown wake is tried with a low that is too short and with one that is long enough, and the power states are also left through the pad. Together these show the qualification threshold and that the oscillator stays off after a voltage-pin wake.

// File: rtl/rst_mode_pkg.sv
package rst_mode_pkg;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_IDLE = 2'd1,
    PWR_DOWN = 2'd2
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchStraps;
    logic clearModes;
    logic wakeArm;
  } dpStrobe_t;

endpackage

// File: rtl/rst_mode_ctrl.sv
module rst_mode_ctrl
  import rst_mode_pkg::*;
#(
  parameter int PULSE_STATES = 16
) (
  input  logic      clk,
  input  logic      porN,
  input  logic      rstPinIn,
  input  logic      intRstReq,
  input  logic      cfgIntRstQuiet,
  input  logic      idleReq,
  input  logic      pdReq,
  input  logic      pdEnable,
  input  logic      wakeHit,
  output dpStrobe_t strobe,
  output logic      rstPinPullDn,
  output logic      coreRst,
  output logic      bootFetch,
  output logic      idleMode,
  output logic      pdMode,
  output logic      phaseClkEn,
  output logic      oscEn
);

  localparam int CW = $clog2(PULSE_STATES + 1);

  logic          syncA, syncB, syncPrev;
  logic          fallEdge, riseEdge;
  logic [CW-1:0] pulseCnt;
  logic          busy, driveFlag, startPulse;
  logic          coreRstQ, coreRstPrev;
  pwrState_e     pwrState;
  logic          oscEnQ;

  // pad synchroniser and edge detect
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= rstPinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign fallEdge = syncPrev & ~syncB;
  assign riseEdge = ~syncPrev & syncB;

  // pull-down pulse counter
  assign busy       = (pulseCnt != '0);
  assign startPulse = !busy && (fallEdge || intRstReq);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pulseCnt  <= '0;
      driveFlag <= 1'b0;
    end else if (startPulse) begin
      pulseCnt  <= CW'(PULSE_STATES);
      driveFlag <= fallEdge | ~cfgIntRstQuiet;
    end else if (busy) begin
      pulseCnt  <= pulseCnt - CW'(1);
    end
  end

  assign rstPinPullDn = busy & driveFlag;

  // core reset and boot strobe
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      coreRstQ    <= 1'b1;
      coreRstPrev <= 1'b1;
    end else begin
      coreRstQ    <= busy | ~syncB;
      coreRstPrev <= coreRstQ;
    end
  end

  assign coreRst   = coreRstQ;
  assign bootFetch = coreRstPrev & ~coreRstQ;

  // power state
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pwrState <= PWR_RUN;
      oscEnQ   <= 1'b1;
    end else if (coreRstQ) begin
      pwrState <= PWR_RUN;
      oscEnQ   <= 1'b1;
    end else begin
      unique case (pwrState)
        PWR_RUN: begin
          if (pdReq && pdEnable) begin
            pwrState <= PWR_DOWN;
            oscEnQ   <= 1'b0;
          end else if (idleReq) begin
            pwrState <= PWR_IDLE;
          end
        end
        PWR_IDLE: pwrState <= PWR_IDLE;
        PWR_DOWN: if (wakeHit) pwrState <= PWR_RUN;
        default:  pwrState <= PWR_RUN;
      endcase
    end
  end

  assign idleMode   = (pwrState == PWR_IDLE);
  assign pdMode     = (pwrState == PWR_DOWN);
  assign phaseClkEn = (pwrState != PWR_DOWN);
  assign oscEn      = oscEnQ;

  assign strobe.latchStraps = riseEdge;
  assign strobe.clearModes  = ~syncB;
  assign strobe.wakeArm     = (pwrState == PWR_DOWN);

  // checker state: length of the current pull-down run
  logic [CW:0] chkLen;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)             chkLen <= '0;
    else if (rstPinPullDn) chkLen <= chkLen + 1'b1;
    else                   chkLen <= '0;
  end

  // R1
  pulse_len_chk: assert property (@(posedge clk) disable iff (!porN)
    (!rstPinPullDn && $past(rstPinPullDn)) |-> (chkLen == (CW+1)'(PULSE_STATES)));

  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (!porN)
    (busy && (fallEdge || intRstReq)) |=> (pulseCnt < $past(pulseCnt)));

  // R3
  core_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (!syncB || busy) |=> coreRst);

  // R8
  pd_gate_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(pdMode) |-> $past(pdEnable));

  // R9
  osc_stay_chk: assert property (@(posedge clk) disable iff (!porN)
    (pdMode && wakeHit && !coreRst) |=> (!oscEn && phaseClkEn));

endmodule

// File: rtl/rst_mode_dp.sv
module rst_mode_dp
  import rst_mode_pkg::*;
#(
  parameter int          NUM_PINS    = 16,
  parameter int          OSC_PIN_A   = 14,
  parameter int          OSC_PIN_B   = 15,
  parameter int          WAKE_CYCLES = 5,
  parameter logic [15:0] RESET_VEC   = 16'h2080
) (
  input  logic                clk,
  input  logic                porN,
  input  dpStrobe_t           strobe,
  input  logic                emuStrapN,
  input  logic                testStrapN,
  input  logic                vppN,
  output logic                wakeHit,
  output logic                modeNormal,
  output logic                modeEmu,
  output logic                modeTest,
  output logic [NUM_PINS-1:0] pinTristate,
  output logic [15:0]         bootAddr
);

  localparam int WW = $clog2(WAKE_CYCLES + 1);

  logic          emuQ, testQ;
  logic          vppA, vppB;
  logic [WW-1:0] wakeCnt;

  // strap latch, emulation wins over test
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      emuQ  <= 1'b0;
      testQ <= 1'b0;
    end else if (strobe.clearModes) begin
      emuQ  <= 1'b0;
      testQ <= 1'b0;
    end else if (strobe.latchStraps) begin
      emuQ  <= ~emuStrapN;
      testQ <= ~testStrapN & emuStrapN;
    end
  end

  assign modeEmu    = emuQ;
  assign modeTest   = testQ;
  assign modeNormal = ~emuQ & ~testQ;

  // per-pin tristate, oscillator pins excluded
  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    if (i == OSC_PIN_A || i == OSC_PIN_B) begin : gOsc
      assign pinTristate[i] = 1'b0;
    end else begin : gIo
      assign pinTristate[i] = emuQ;
    end
  end

  // programming-voltage wake qualification
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      vppA <= 1'b1;
      vppB <= 1'b1;
    end else begin
      vppA <= vppN;
      vppB <= vppA;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wakeCnt <= '0;
    end else if (strobe.wakeArm && !vppB) begin
      if (wakeCnt != WW'(WAKE_CYCLES - 1)) wakeCnt <= wakeCnt + WW'(1);
    end else begin
      wakeCnt <= '0;
    end
  end

  assign wakeHit  = strobe.wakeArm & ~vppB & (wakeCnt == WW'(WAKE_CYCLES - 1));
  assign bootAddr = RESET_VEC;

  // R6
  mode_excl_chk: assert property (@(posedge clk) disable iff (!porN)
    !(modeEmu && modeTest));

  // R4
  mode_clear_chk: assert property (@(posedge clk) disable iff (!porN)
    strobe.clearModes |=> (!modeEmu && !modeTest));

  // R5
  tri_on_chk: assert property (@(posedge clk) disable iff (!porN)
    modeEmu |-> ($countones(pinTristate) == NUM_PINS - 2));

  // R5
  tri_off_chk: assert property (@(posedge clk) disable iff (!porN)
    !modeEmu |-> (pinTristate == '0));

endmodule

// File: rtl/rst_mode_ctl.sv
module rst_mode_ctl
  import rst_mode_pkg::*;
#(
  parameter int          PULSE_STATES = 16,
  parameter int          NUM_PINS     = 16,
  parameter int          OSC_PIN_A    = 14,
  parameter int          OSC_PIN_B    = 15,
  parameter int          WAKE_CYCLES  = 5,
  parameter logic [15:0] RESET_VEC    = 16'h2080
) (
  input  logic                clk,
  input  logic                porN,
  input  logic                rstPinIn,
  output logic                rstPinPullDn,
  input  logic                intRstReq,
  input  logic                cfgIntRstQuiet,
  input  logic                emuStrapN,
  input  logic                testStrapN,
  input  logic                idleReq,
  input  logic                pdReq,
  input  logic                pdEnable,
  input  logic                vppN,
  output logic                coreRst,
  output logic                bootFetch,
  output logic [15:0]         bootAddr,
  output logic                modeNormal,
  output logic                modeEmu,
  output logic                modeTest,
  output logic [NUM_PINS-1:0] pinTristate,
  output logic                idleMode,
  output logic                pdMode,
  output logic                phaseClkEn,
  output logic                oscEn
);

  dpStrobe_t strobe;
  logic      wakeHit;

  rst_mode_ctrl #(.PULSE_STATES(PULSE_STATES)) u_ctrl (
    .clk(clk), .porN(porN), .rstPinIn(rstPinIn), .intRstReq(intRstReq),
    .cfgIntRstQuiet(cfgIntRstQuiet), .idleReq(idleReq), .pdReq(pdReq),
    .pdEnable(pdEnable), .wakeHit(wakeHit), .strobe(strobe),
    .rstPinPullDn(rstPinPullDn), .coreRst(coreRst), .bootFetch(bootFetch),
    .idleMode(idleMode), .pdMode(pdMode), .phaseClkEn(phaseClkEn), .oscEn(oscEn)
  );

  rst_mode_dp #(
    .NUM_PINS(NUM_PINS), .OSC_PIN_A(OSC_PIN_A), .OSC_PIN_B(OSC_PIN_B),
    .WAKE_CYCLES(WAKE_CYCLES), .RESET_VEC(RESET_VEC)
  ) u_dp (
    .clk(clk), .porN(porN), .strobe(strobe), .emuStrapN(emuStrapN),
    .testStrapN(testStrapN), .vppN(vppN), .wakeHit(wakeHit),
    .modeNormal(modeNormal), .modeEmu(modeEmu), .modeTest(modeTest),
    .pinTristate(pinTristate), .bootAddr(bootAddr)
  );

endmodule

// File: tb/rst_mode_ctl_tb.sv
module rst_mode_ctl_tb;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        extLow = 1'b0;
  logic        rstPinIn, rstPinPullDn;
  logic        intRstReq = 1'b0, cfgIntRstQuiet = 1'b0;
  logic        emuStrapN = 1'b1, testStrapN = 1'b1;
  logic        idleReq = 1'b0, pdReq = 1'b0, pdEnable = 1'b0, vppN = 1'b1;
  logic        coreRst, bootFetch, modeNormal, modeEmu, modeTest;
  logic [15:0] bootAddr, pinTristate;
  logic        idleMode, pdMode, phaseClkEn, oscEn;

  int checks = 0, fails = 0;
  int bootSeen = 0, expBoots = 0, pulseSeen = 0;
  int runLen = 0;
  bit done = 1'b0;
  int pulseQ[$];

  always #2.5 clk = ~clk;

  // open-drain pad model
  assign rstPinIn = ~(extLow | rstPinPullDn);

  rst_mode_ctl u_dut (
    .clk(clk), .porN(porN), .rstPinIn(rstPinIn), .rstPinPullDn(rstPinPullDn),
    .intRstReq(intRstReq), .cfgIntRstQuiet(cfgIntRstQuiet),
    .emuStrapN(emuStrapN), .testStrapN(testStrapN), .idleReq(idleReq),
    .pdReq(pdReq), .pdEnable(pdEnable), .vppN(vppN), .coreRst(coreRst),
    .bootFetch(bootFetch), .bootAddr(bootAddr), .modeNormal(modeNormal),
    .modeEmu(modeEmu), .modeTest(modeTest), .pinTristate(pinTristate),
    .idleMode(idleMode), .pdMode(pdMode), .phaseClkEn(phaseClkEn), .oscEn(oscEn)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected pulse lengths, checks boot address
  always @(negedge clk) begin
    if (porN) begin
      if (rstPinPullDn) runLen++;
      else if (runLen != 0) begin
        pulseSeen++;
        if (pulseQ.size() == 0) chk("R2 unexpected pulse", runLen, 0);
        else chk("R1 pulse length", runLen, pulseQ.pop_front());
        runLen = 0;
      end
      if (bootFetch) begin
        bootSeen++;
        chk("R3 boot address", bootAddr, 16'h2080);
      end
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // external pad reset with straps held
  task automatic extReset(int lowCycles, logic eN, logic tN);
    emuStrapN  = eN;
    testStrapN = tN;
    pulseQ.push_back(16);
    expBoots++;
    extLow = 1'b1;
    for (int i = 0; i < lowCycles + 30; i++) begin
      if (i == lowCycles) extLow = 1'b0;
      if (i == 6) begin
        chk("R4 modes cleared while pad low", {modeEmu, modeTest}, 2'b00);
        chk("R3 core reset held", coreRst, 1'b1);
      end
      if (lowCycles > 20 && i == lowCycles - 2) chk("R3 held after pulse", coreRst, 1'b1);
      if (lowCycles > 20 && i == lowCycles + 2) chk("R3 still held", coreRst, 1'b1);
      if (lowCycles > 20 && i == lowCycles + 3) begin
        chk("R3 released", coreRst, 1'b0);
        chk("R3 boot strobe", bootFetch, 1'b1);
      end
      @(negedge clk);
    end
  endtask

  task automatic intReset();
    intRstReq = 1'b1;
    @(negedge clk);
    intRstReq = 1'b0;
  endtask

  initial begin
    int pBefore;
    expBoots = 1;
    waitCyc(3);
    porN = 1'b1;
    waitCyc(10);
    chk("R3 reset state core", coreRst, 1'b0);
    chk("R6 reset state normal", modeNormal, 1'b1);
    chk("R1 reset state pad idle", rstPinPullDn, 1'b0);
    chk("R10 reset state power", {pdMode, idleMode, phaseClkEn, oscEn}, 4'b0011);
    chk("R3 boot after power-on", bootSeen, 1);

    // emulation strap, short pad low
    extReset(4, 1'b0, 1'b1);
    chk("R4 emulation latched", {modeEmu, modeTest, modeNormal}, 3'b100);
    chk("R5 tristate vector", pinTristate, 16'h3FFF);

    // long pad low, test strap only
    extReset(40, 1'b1, 1'b0);
    chk("R2 single pulse on long low", pulseSeen, 2);
    chk("R6 test latched", {modeEmu, modeTest, modeNormal}, 3'b010);
    chk("R5 no tristate outside emulation", pinTristate, 16'h0000);

    // both straps low
    extReset(4, 1'b0, 1'b0);
    chk("R6 emulation priority", {modeEmu, modeTest}, 2'b10);

    // loud internal reset re-captures straps
    emuStrapN = 1'b1; testStrapN = 1'b1;
    pulseQ.push_back(16);
    expBoots++;
    intReset();
    waitCyc(3);
    intReset();
    waitCyc(40);
    chk("R1 internal pulse count", pulseSeen, 4);
    chk("R1 internal reset recaptured", modeNormal, 1'b1);

    // quiet internal reset from emulation mode
    extReset(4, 1'b0, 1'b1);
    cfgIntRstQuiet = 1'b1;
    emuStrapN = 1'b1;
    pBefore = pulseSeen;
    expBoots++;
    intReset();
    waitCyc(5);
    chk("R7 core reset asserted", coreRst, 1'b1);
    chk("R7 pad not driven", rstPinPullDn, 1'b0);
    waitCyc(30);
    chk("R7 no pulse on pad", pulseSeen, pBefore);
    chk("R7 mode unchanged", modeEmu, 1'b1);
    chk("R7 core released", coreRst, 1'b0);
    cfgIntRstQuiet = 1'b0;
    extReset(4, 1'b1, 1'b1);

    // powerdown gated by enable
    pdEnable = 1'b0;
    pdReq = 1'b1; @(negedge clk); pdReq = 1'b0;
    waitCyc(3);
    chk("R8 request ignored", {pdMode, phaseClkEn, oscEn}, 3'b011);

    // idle then pad reset
    idleReq = 1'b1; @(negedge clk); idleReq = 1'b0;
    waitCyc(2);
    chk("R11 idle entered", {idleMode, phaseClkEn}, 2'b11);
    extReset(4, 1'b1, 1'b1);
    chk("R10 idle left by pad reset", {idleMode, pdMode, oscEn}, 3'b001);

    // enabled powerdown, wake qualification
    pdEnable = 1'b1;
    pdReq = 1'b1; @(negedge clk); pdReq = 1'b0;
    waitCyc(2);
    chk("R8 powerdown entered", {pdMode, phaseClkEn, oscEn}, 3'b100);
    vppN = 1'b0; waitCyc(3); vppN = 1'b1;
    waitCyc(6);
    chk("R9 short low ignored", pdMode, 1'b1);
    vppN = 1'b0; waitCyc(10); vppN = 1'b1;
    waitCyc(3);
    chk("R9 woke, clocks on, oscillator off", {pdMode, phaseClkEn, oscEn}, 3'b010);

    // powerdown left by pad reset
    pdReq = 1'b1; @(negedge clk); pdReq = 1'b0;
    waitCyc(2);
    chk("R8 powerdown again", pdMode, 1'b1);
    extReset(4, 1'b1, 1'b1);
    chk("R10 powerdown left by pad reset", {pdMode, phaseClkEn, oscEn}, 3'b011);

    waitCyc(5);
    chk("R1 all expected pulses seen", pulseQ.size(), 0);
    chk("R3 boot count", bootSeen, expBoots);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule